// File: doc/BRIEF.md
# Lockstep Master-Checker Bus Comparator

This block adds functional-redundancy monitoring to a processor bus interface. A mode input decides the role of the instance. As a master, it drives the shared bus. As a checker, it keeps its drivers off and listens. In checker mode, each bus cycle compares the address, control and write data that its own core would have driven with the values the master places on the bus. A difference raises a fault indication that an external majority voter can sample.

One output pin has two meanings that depend on the mode. In master mode it carries the core's bus-lock request. In checker mode it carries the mismatch flag. A freeze input halts bus activity and holds the comparison state. A recovery strap picks how the core handles the faulty instruction: either a retry request that rolls the instruction back, or an exception request that rolls forward. The block sends one such request pulse to the core for each bus cycle in which it finds a mismatch.

Top module: `lockstep_cmp`

## Requirements
- R1: During and right after synchronous reset, lock_mism_o, retry_req_o, exc_req_o and bus_drive_en_o are all 0, and any mismatch state is cleared.
- R2: bus_drive_en_o is registered. One clock after an edge where checker_mode_i=0 and freeze_i=0 it is 1. It is 0 after any edge where checker_mode_i=1 or freeze_i=1.
- R3: In master mode (checker_mode_i=0), lock_mism_o equals core_lock_i as sampled at the previous edge. No comparison takes place, and retry_req_o and exc_req_o stay 0.
- R4: In checker mode with freeze_i=0, an edge where addr_end_i=1 and the bus address or bus control differs from the core's value sets lock_mism_o to 1 from the next cycle on.
- R5: In checker mode with freeze_i=0, an edge where wdata_end_i=1 and the bus write data differs from the core's value, in any bit, sets lock_mism_o to 1 from the next cycle on.
- R6: An address or control difference while addr_end_i=0 has no effect. A data difference while wdata_end_i=0 (read data or an idle cycle) also has no effect.
- R7: Once set, lock_mism_o stays 1 until the edge after which cycle_done_i=1 is sampled, and it falls at that edge. If a new difference is sampled in that same cycle, setting takes priority and the flag stays 1.
- R8: When the flag goes from clear to set, the block drives one single-cycle pulse in the same cycle that lock_mism_o rises. The pulse is on retry_req_o if recover_exc_i=0 (retry) at detection, or on exc_req_o if recover_exc_i=1 (exception). The two pulses are never high together.
- R9: A further difference detected while the flag is already set produces no additional pulse.
- R10: While freeze_i=1 in checker mode, no new mismatch is flagged and no pulse is produced. The flag keeps its value, and cycle_done_i does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| checker_mode_i | input | 1 | 0 = master (drives bus), 1 = checker (listens) |
| freeze_i | input | 1 | Halts bus operation and holds comparison state |
| recover_exc_i | input | 1 | Recovery strap: 0 = retry, 1 = exception |
| addr_end_i | input | 1 | End of address phase: address and control valid |
| wdata_end_i | input | 1 | End of write data phase: write data valid |
| cycle_done_i | input | 1 | Current bus cycle completes |
| core_addr_i | input | AW | Address the own core would drive |
| core_ctrl_i | input | CW | Control the own core would drive |
| core_wdata_i | input | DW | Write data the own core would drive |
| core_lock_i | input | 1 | Core bus-lock request |
| bus_addr_i | input | AW | Address seen on the shared bus |
| bus_ctrl_i | input | CW | Control seen on the shared bus |
| bus_wdata_i | input | DW | Write data seen on the shared bus |
| bus_drive_en_o | output | 1 | Enables this instance's bus drivers |
| lock_mism_o | output | 1 | Lock request (master) or mismatch flag (checker) |
| retry_req_o | output | 1 | One-cycle retry request to the core |
| exc_req_o | output | 1 | One-cycle exception request to the core |

## Verification
The properties assume that the mode input changes only between bus cycles. They also assume that the phase strobes are single-cycle marks given by a well-formed bus sequencer. They assume nothing about how strobes and freeze combine, so the freeze and pulse properties must hold for any overlap of freeze with the strobes and cycle_done_i. The stimulus changes mode only while no mismatch is pending and drives every input half a clock away from the sampling edge. It deliberately overlaps freeze with done and strobes, and a difference with done, to reach the priority rules.

// File: rtl/lockstep_cmp_pkg.sv
package lockstep_cmp_pkg;
  typedef enum logic {
    RECOVER_RETRY  = 1'b0,
    RECOVER_EXCEPT = 1'b1
  } recover_e;

  typedef struct packed {
    logic addr_hit;
    logic ctrl_hit;
    logic data_hit;
  } cmp_hit_t;
endpackage

// File: rtl/lockstep_lane_cmp.sv
module lockstep_lane_cmp #(
  parameter int W     = 32,
  parameter int LANES = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  localparam int LW = (W + LANES - 1) / LANES;
  localparam int PW = LW * LANES;

  logic [PW-1:0]    a_pad, b_pad;
  logic [LANES-1:0] lane_diff;

  always_comb begin
    a_pad = '0;
    b_pad = '0;
    a_pad[W-1:0] = a_i;
    b_pad[W-1:0] = b_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_diff[l] = |(a_pad[l*LW +: LW] ^ b_pad[l*LW +: LW]);
  end

  assign diff_o = |lane_diff;
endmodule

// File: rtl/lockstep_fault_track.sv
module lockstep_fault_track
  import lockstep_cmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     checker_i,
  input  logic     freeze_i,
  input  logic     hit_i,
  input  logic     done_i,
  input  recover_e recover_i,
  output logic     flag_d_o,
  output logic     retry_q_o,
  output logic     exc_q_o
);
  logic flag_q;
  logic new_evt;

  always_comb begin
    flag_d_o = flag_q;
    if (!checker_i) begin
      flag_d_o = 1'b0;
    end else if (!freeze_i) begin
      if (hit_i)       flag_d_o = 1'b1;
      else if (done_i) flag_d_o = 1'b0;
    end
  end

  assign new_evt = checker_i && !freeze_i && hit_i && !flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      retry_q_o <= 1'b0;
      exc_q_o   <= 1'b0;
    end else begin
      flag_q    <= flag_d_o;
      retry_q_o <= new_evt && (recover_i == RECOVER_RETRY);
      exc_q_o   <= new_evt && (recover_i == RECOVER_EXCEPT);
    end
  end
endmodule

// File: rtl/lockstep_pin_mux.sv
module lockstep_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic checker_i,
  input  logic freeze_i,
  input  logic lock_req_i,
  input  logic flag_d_i,
  output logic pin_o,
  output logic drive_en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o      <= 1'b0;
      drive_en_o <= 1'b0;
    end else begin
      pin_o      <= checker_i ? flag_d_i : lock_req_i;
      drive_en_o <= !checker_i && !freeze_i;
    end
  end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lockstep_cmp_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          checker_mode_i,
  input  logic          freeze_i,
  input  logic          recover_exc_i,
  input  logic          addr_end_i,
  input  logic          wdata_end_i,
  input  logic          cycle_done_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [CW-1:0] core_ctrl_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          core_lock_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [CW-1:0] bus_ctrl_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic          bus_drive_en_o,
  output logic          lock_mism_o,
  output logic          retry_req_o,
  output logic          exc_req_o
);
  localparam int CLANES = (CW < LANES) ? CW : LANES;

  logic     addr_diff, ctrl_diff, data_diff;
  cmp_hit_t hits;
  logic     any_hit;
  logic     flag_d;
  recover_e recover;

  lockstep_lane_cmp #(.W(AW), .LANES(LANES)) u_addr_cmp (
    .a_i(core_addr_i), .b_i(bus_addr_i), .diff_o(addr_diff));
  lockstep_lane_cmp #(.W(CW), .LANES(CLANES)) u_ctrl_cmp (
    .a_i(core_ctrl_i), .b_i(bus_ctrl_i), .diff_o(ctrl_diff));
  lockstep_lane_cmp #(.W(DW), .LANES(LANES)) u_data_cmp (
    .a_i(core_wdata_i), .b_i(bus_wdata_i), .diff_o(data_diff));

  always_comb begin
    hits.addr_hit = addr_end_i && addr_diff;
    hits.ctrl_hit = addr_end_i && ctrl_diff;
    hits.data_hit = wdata_end_i && data_diff;
  end

  assign any_hit = hits.addr_hit || hits.ctrl_hit || hits.data_hit;
  assign recover = recover_exc_i ? RECOVER_EXCEPT : RECOVER_RETRY;

  lockstep_fault_track u_fault (
    .clk       (clk),
    .rst       (rst),
    .checker_i (checker_mode_i),
    .freeze_i  (freeze_i),
    .hit_i     (any_hit),
    .done_i    (cycle_done_i),
    .recover_i (recover),
    .flag_d_o  (flag_d),
    .retry_q_o (retry_req_o),
    .exc_q_o   (exc_req_o)
  );

  lockstep_pin_mux u_pin (
    .clk        (clk),
    .rst        (rst),
    .checker_i  (checker_mode_i),
    .freeze_i   (freeze_i),
    .lock_req_i (core_lock_i),
    .flag_d_i   (flag_d),
    .pin_o      (lock_mism_o),
    .drive_en_o (bus_drive_en_o)
  );
endmodule

// File: rtl/lockstep_cmp_props.sv
module lockstep_cmp_props (
  input logic clk,
  input logic rst,
  input logic checker_mode_i,
  input logic freeze_i,
  input logic lock_mism_o,
  input logic retry_req_o,
  input logic exc_req_o,
  input logic bus_drive_en_o
);
  // R8: never both recovery requests at once
  p_one_kind_r8: assert property (@(posedge clk) disable iff (rst)
    !(retry_req_o && exc_req_o));

  // R8: a request pulse comes with the raised mismatch pin
  p_pulse_with_pin_r8: assert property (@(posedge clk) disable iff (rst)
    (retry_req_o || exc_req_o) |-> lock_mism_o);

  // R2: checker never drives the bus
  p_checker_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (checker_mode_i || freeze_i) |=> !bus_drive_en_o);

  // R3: master mode never requests recovery
  p_master_no_req_r3: assert property (@(posedge clk) disable iff (rst)
    !checker_mode_i |=> (!retry_req_o && !exc_req_o));

  // R10: freeze blocks pulses
  p_freeze_no_req_r10: assert property (@(posedge clk) disable iff (rst)
    (checker_mode_i && freeze_i) |=> (!retry_req_o && !exc_req_o));

  // R10: freeze holds the flag
  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (checker_mode_i && freeze_i && $past(checker_mode_i)) |=> $stable(lock_mism_o));
endmodule

bind lockstep_cmp lockstep_cmp_props u_props (
  .clk            (clk),
  .rst            (rst),
  .checker_mode_i (checker_mode_i),
  .freeze_i       (freeze_i),
  .lock_mism_o    (lock_mism_o),
  .retry_req_o    (retry_req_o),
  .exc_req_o      (exc_req_o),
  .bus_drive_en_o (bus_drive_en_o)
);

// File: tb/lockstep_cmp_test.sv
module lockstep_cmp_test;
  localparam int AW = 32, DW = 32, CW = 4;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk = 1'b0, frz = 1'b0, rexc = 1'b0;
  logic ae = 1'b0, we = 1'b0, dn = 1'b0, lk = 1'b0;
  logic [AW-1:0] c_addr = 32'h1234_5678, b_addr = 32'h1234_5678;
  logic [CW-1:0] c_ctrl = 4'h5, b_ctrl = 4'h5;
  logic [DW-1:0] c_data = 32'hCAFE_0001, b_data = 32'hCAFE_0001;
  logic drv, pin, rt, ex;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lockstep_cmp uut (
    .clk(clk), .rst(rst), .checker_mode_i(chk), .freeze_i(frz),
    .recover_exc_i(rexc), .addr_end_i(ae), .wdata_end_i(we),
    .cycle_done_i(dn), .core_addr_i(c_addr), .core_ctrl_i(c_ctrl),
    .core_wdata_i(c_data), .core_lock_i(lk), .bus_addr_i(b_addr),
    .bus_ctrl_i(b_ctrl), .bus_wdata_i(b_data), .bus_drive_en_o(drv),
    .lock_mism_o(pin), .retry_req_o(rt), .exc_req_o(ex));

  // {chk,frz,rexc,ae,we,dn,addr_diff,data_diff,lk, exp_pin,exp_rt,exp_ex,exp_drv}
  localparam logic [12:0] VEC [0:NV-1] = '{
    13'b0_0_0_0_0_0_0_0_1_1001, // 0  R3 lock passes
    13'b0_0_0_1_0_0_1_0_0_0001, // 1  R3 no compare in master
    13'b1_0_0_1_0_0_0_0_0_0000, // 2  R2 checker no drive
    13'b1_0_0_0_0_0_0_1_0_0000, // 3  R6 data diff outside phase
    13'b1_0_0_0_0_0_1_0_0_0000, // 4  R6 addr diff outside phase
    13'b1_0_0_1_0_0_1_0_0_1100, // 5  R4 R8 retry
    13'b1_0_0_0_1_0_0_1_0_1000, // 6  R9 no second pulse
    13'b1_0_0_0_0_0_0_0_0_1000, // 7  R7 held
    13'b1_0_0_0_0_1_0_0_0_0000, // 8  R7 cleared by done
    13'b1_0_1_0_1_0_0_1_0_1010, // 9  R5 R8 exception
    13'b1_1_0_0_0_1_0_0_0_1000, // 10 R10 done ignored
    13'b1_1_0_1_0_0_1_0_0_1000, // 11 R10 no pulse
    13'b1_0_0_0_0_1_0_0_0_0000, // 12 R7 clear
    13'b1_1_0_1_0_0_1_0_0_0000, // 13 R10 no new flag
    13'b1_0_0_0_1_1_0_1_0_1100, // 14 R7 set wins over done
    13'b1_0_0_0_0_1_0_0_0_0000, // 15 R7 clear
    13'b0_1_0_0_0_0_0_0_0_0000, // 16 R2 freeze stops drive
    13'b0_0_0_0_0_0_0_0_0_0001  // 17 R2 master drives
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ae = 0; we = 0; dn = 0; frz = 0;
    b_addr = c_addr; b_ctrl = c_ctrl; b_data = c_data;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step_edge();
    check("R1 pin", pin, 1'b0);
    check("R1 retry", rt, 1'b0);
    check("R1 exc", ex, 1'b0);
    check("R1 drive", drv, 1'b0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      chk = v[12]; frz = v[11]; rexc = v[10]; ae = v[9]; we = v[8]; dn = v[7];
      b_addr = c_addr ^ {31'b0, v[6]};
      b_data = c_data ^ {31'b0, v[5]};
      lk = v[4];
      step_edge();
      check($sformatf("vec %0d pin", i), pin, v[3]);
      check($sformatf("vec %0d retry", i), rt, v[2]);
      check($sformatf("vec %0d exc", i), ex, v[1]);
      check($sformatf("vec %0d drive", i), drv, v[0]);
    end

    // R4: control-only difference at address end
    chk = 1; lk = 0; rexc = 0; idle_inputs();
    step_edge();
    ae = 1; b_ctrl = c_ctrl ^ 4'b1000;
    step_edge();
    check("R4 ctrl diff pin", pin, 1'b1);
    check("R8 ctrl diff retry", rt, 1'b1);
    idle_inputs();
    step_edge();
    check("R8 single pulse", rt, 1'b0);
    dn = 1;
    step_edge();
    check("R7 clear after ctrl", pin, 1'b0);

    // R5: top data bit difference, exception strap
    idle_inputs(); rexc = 1;
    we = 1; b_data = c_data ^ 32'h8000_0000;
    step_edge();
    check("R5 high data bit pin", pin, 1'b1);
    check("R8 exc pulse", ex, 1'b1);
    check("R8 no retry", rt, 1'b0);

    // R1: reset clears pending mismatch
    idle_inputs(); rst = 1;
    step_edge();
    check("R1 reset clears pin", pin, 1'b0);
    rst = 0;
    step_edge();
    check("R1 stays clear", pin, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule